// File: doc/BRIEF.md
# Packed Binary32-to-Binary64 Widening Unit with Lane Masking

This block widens packed IEEE-754 single-precision values into double-precision values. Up to eight 32-bit lanes from a 256-bit source are widened. Each widened 64-bit lane is written into a 512-bit destination vector. Three selects shape the write:

- A vector-length select sets how many lanes take part.
- An encoding-mode select decides what happens to the destination bits above that length.
- A masking-mode select decides how a per-lane write mask is honoured.

A broadcast flag makes every written lane widen the lowest source element.

The result and two exception flags (invalid operation and denormal operand) are registered. Both appear one clock after the inputs are presented. Instruction decode, memory access and trap handling are left to the surrounding pipeline. The pipeline supplies the previous destination value, and it acts on the flags.

Top module: `sp2dp_widen`

## Requirements
- R1: The vector-length select maps to a lane count: code 0 gives 2 lanes (128 bits), code 1 gives 4 lanes (256 bits), codes 2 and 3 give 8 lanes (512 bits).
- R2: Result lane j occupies bits [64j+63:64j] and is widened from source bits [32j+31:32j].
- R3: A normal binary32 input is widened exactly: the sign is kept, the exponent gains 896, and the fraction gets 29 zero bits appended below it.
- R4: The write mask applies only in the extended encoding (codes 2 and 3) with masking mode merge (code 1) or zero (code 2). In that case a lane whose mask bit is clear keeps its previous destination value under merge and becomes zero under zero. Masking mode codes 0 and 3 write every lane within the length.
- R5: In the extended encoding with the broadcast flag set, every written lane widens source bits [31:0].
- R6: In the VEX-style and extended encodings (codes 1 to 3), result bits above the selected vector length are zero.
- R7: In the legacy encoding (code 0), the length is 128 bits whatever the length select says, and result bits [511:128] keep their previous destination value. Under legacy and VEX-style encodings, the mask, masking mode and broadcast flag have no effect.
- R8: A binary32 subnormal input becomes the exactly equal normal binary64 value and raises the denormal flag.
- R9: Signed zeros and infinities keep their sign and class. They raise no flag.
- R10: A signalling NaN (fraction bit 22 clear, fraction nonzero) becomes a quiet NaN with the same sign and payload and raises the invalid flag. A quiet NaN passes through the same way without a flag.
- R11: The flags are the OR over written lanes only. Lanes outside the length and masked-off lanes never raise a flag.
- R12: Result and flags are registered with one clock of latency, and an active-low asynchronous reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 256 | Packed binary32 source lanes |
| prev_i | input | 512 | Previous destination value |
| mask_i | input | 8 | Per-lane write mask |
| vlen_i | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| mmode_i | input | 2 | Masking mode: 0=none, 1=merge, 2=zero, 3=none |
| bcast_i | input | 1 | Broadcast lowest source element |
| enc_i | input | 2 | Encoding: 0=legacy, 1=VEX-style, 2/3=extended |
| res_o | output | 512 | Packed binary64 result |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |

## Verification
The bench builds the unit with its default parameters: eight lanes, 32-bit and 64-bit element widths, and the extended-encoding logic enabled. This brings merge and zero masking, broadcast and the full 512-bit length within reach, alongside the two narrower encodings.

Directed vectors cover the following:
- every floating-point class: zeros, subnormals, infinities, and both kinds of NaN;
- flag suppression in masked or out-of-length lanes;
- settings that are ignored under legacy and VEX-style encodings.

Mixed random vectors then exercise lane placement under all control combinations.

// File: rtl/sp2dp_pkg.sv
package sp2dp_pkg;

   typedef enum logic [1:0] {
      ENC_LEGACY = 2'd0,
      ENC_VEXS   = 2'd1,
      ENC_EXT    = 2'd2,
      ENC_EXT_B  = 2'd3
   } enc_e;

   typedef enum logic [1:0] {
      MM_NONE   = 2'd0,
      MM_MERGE  = 2'd1,
      MM_ZERO   = 2'd2,
      MM_NONE_B = 2'd3
   } mmode_e;

   typedef enum logic [1:0] {
      VL_128   = 2'd0,
      VL_256   = 2'd1,
      VL_512   = 2'd2,
      VL_512_B = 2'd3
   } vlen_e;

   localparam int unsigned SP_EXP_W  = 8;
   localparam int unsigned SP_FRAC_W = 23;
   localparam int unsigned DP_EXP_W  = 11;
   localparam int unsigned DP_FRAC_W = 52;

endpackage

// File: rtl/sp2dp_msb_find.sv
module sp2dp_msb_find #(
   parameter int unsigned W     = 23,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (W < 2) begin : g_bad
         $error("sp2dp_msb_find: W must be at least 2");
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(W); i++) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/sp2dp_lane_cvt.sv
module sp2dp_lane_cvt
   import sp2dp_pkg::*;
#(
   parameter int unsigned SE = SP_EXP_W,
   parameter int unsigned SF = SP_FRAC_W,
   parameter int unsigned DE = DP_EXP_W,
   parameter int unsigned DF = DP_FRAC_W,
   localparam int unsigned SW = 1 + SE + SF,
   localparam int unsigned DW = 1 + DE + DF,
   localparam int unsigned BIAS_GAP = ((1 << (DE - 1)) - 1) - ((1 << (SE - 1)) - 1),
   localparam int unsigned PAD_W = DF - SF,
   localparam int unsigned IDX_W = $clog2(SF)
) (
   input  logic [SW-1:0] sp_i,
   output logic [DW-1:0] dp_o,
   output logic          snan_o,
   output logic          sub_o
);

   generate
      if (DE <= SE || DF <= SF) begin : g_bad
         $error("sp2dp_lane_cvt: destination format must be wider");
      end
   endgenerate

   logic          sgn;
   logic [SE-1:0] exp_in;
   logic [SF-1:0] frc_in;
   logic [IDX_W-1:0] top_bit;
   logic [IDX_W:0]   shamt;
   logic [SF:0]      norm_frc;

   assign sgn    = sp_i[SW-1];
   assign exp_in = sp_i[SW-2 -: SE];
   assign frc_in = sp_i[SF-1:0];

   sp2dp_msb_find #(.W(SF)) u_msb (
      .vec_i (frc_in),
      .idx_o (top_bit)
   );

   always_comb begin
      shamt    = (IDX_W+1)'(SF) - {1'b0, top_bit};
      norm_frc = {1'b0, frc_in} << shamt;
   end

   always_comb begin
      dp_o   = '0;
      snan_o = 1'b0;
      sub_o  = 1'b0;
      if (exp_in == '1) begin
         if (frc_in == '0) begin
            dp_o = {sgn, {DE{1'b1}}, {DF{1'b0}}};
         end else begin
            dp_o   = {sgn, {DE{1'b1}}, 1'b1, frc_in[SF-2:0], {PAD_W{1'b0}}};
            snan_o = ~frc_in[SF-1];
         end
      end else if (exp_in == '0) begin
         if (frc_in == '0) begin
            dp_o = {sgn, {(DW-1){1'b0}}};
         end else begin
            dp_o  = {sgn,
                     DE'(BIAS_GAP - SF + 1) + DE'(top_bit),
                     norm_frc[SF-1:0], {PAD_W{1'b0}}};
            sub_o = 1'b1;
         end
      end else begin
         dp_o = {sgn, DE'(exp_in) + DE'(BIAS_GAP), frc_in, {PAD_W{1'b0}}};
      end
   end

endmodule

// File: rtl/sp2dp_lane_ctl.sv
module sp2dp_lane_ctl
   import sp2dp_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter bit          EXT_EN  = 1'b1,
   localparam int unsigned CNT_W  = $clog2(LANES) + 1
) (
   input  logic [1:0]       enc_i,
   input  logic [1:0]       vlen_i,
   input  logic [1:0]       mmode_i,
   input  logic             bcast_i,
   input  logic [LANES-1:0] mask_i,
   output logic [LANES-1:0] in_len_o,
   output logic [LANES-1:0] write_o,
   output logic [LANES-1:0] keep_o,
   output logic             bcast_o
);

   enc_e   enc;
   mmode_e mmode;
   vlen_e  vlen;
   logic   is_legacy;
   logic   mask_on;
   logic   merge_sel;
   logic [CNT_W-1:0] lane_cnt;

   assign enc       = enc_e'(enc_i);
   assign mmode     = mmode_e'(mmode_i);
   assign vlen      = vlen_e'(vlen_i);
   assign is_legacy = (enc == ENC_LEGACY);

   generate
      if (EXT_EN) begin : g_ext
         logic is_ext;
         assign is_ext    = (enc == ENC_EXT) || (enc == ENC_EXT_B);
         assign mask_on   = is_ext && ((mmode == MM_MERGE) || (mmode == MM_ZERO));
         assign merge_sel = (mmode == MM_MERGE);
         assign bcast_o   = is_ext && bcast_i;
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = ^{mmode, bcast_i};
         assign mask_on    = 1'b0;
         assign merge_sel  = 1'b0;
         assign bcast_o    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_legacy) begin
         lane_cnt = CNT_W'(LANES / 4);
      end else begin
         case (vlen)
            VL_128:  lane_cnt = CNT_W'(LANES / 4);
            VL_256:  lane_cnt = CNT_W'(LANES / 2);
            default: lane_cnt = CNT_W'(LANES);
         endcase
      end
   end

   generate
      for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
         assign in_len_o[j] = (CNT_W'(j) < lane_cnt);
         assign write_o[j]  = in_len_o[j] && (!mask_on || mask_i[j]);
         assign keep_o[j]   = in_len_o[j] ? (mask_on && !mask_i[j] && merge_sel)
                                          : is_legacy;
      end
   endgenerate

endmodule

// File: rtl/sp2dp_widen.sv
module sp2dp_widen
   import sp2dp_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned SP_W   = 32,
   parameter int unsigned DP_W   = 64,
   parameter bit          EXT_EN = 1'b1,
   localparam int unsigned SRC_W = LANES * SP_W,
   localparam int unsigned DST_W = LANES * DP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [DST_W-1:0]  prev_i,
   input  logic [LANES-1:0]  mask_i,
   input  logic [1:0]        vlen_i,
   input  logic [1:0]        mmode_i,
   input  logic              bcast_i,
   input  logic [1:0]        enc_i,
   output logic [DST_W-1:0]  res_o,
   output logic              inv_o,
   output logic              den_o
);

   generate
      if (LANES != 8) begin : g_bad_lanes
         $error("sp2dp_widen: LANES must be 8 for the 2/4/8 length map");
      end
      if (SP_W != 1 + SP_EXP_W + SP_FRAC_W || DP_W != 1 + DP_EXP_W + DP_FRAC_W) begin : g_bad_w
         $error("sp2dp_widen: element widths do not match the formats");
      end
   endgenerate

   logic [LANES-1:0] in_len, wr, keep, snan_v, sub_v;
   logic             bcast_eff;
   logic [DST_W-1:0] res_d;

   sp2dp_lane_ctl #(.LANES(LANES), .EXT_EN(EXT_EN)) u_ctl (
      .enc_i    (enc_i),
      .vlen_i   (vlen_i),
      .mmode_i  (mmode_i),
      .bcast_i  (bcast_i),
      .mask_i   (mask_i),
      .in_len_o (in_len),
      .write_o  (wr),
      .keep_o   (keep),
      .bcast_o  (bcast_eff)
   );

   generate
      for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
         logic [SP_W-1:0] sp_sel;
         logic [DP_W-1:0] dp_val;
         logic            snan, sub;

         assign sp_sel = bcast_eff ? src_i[SP_W-1:0] : src_i[j*SP_W +: SP_W];

         sp2dp_lane_cvt u_cvt (
            .sp_i   (sp_sel),
            .dp_o   (dp_val),
            .snan_o (snan),
            .sub_o  (sub)
         );

         assign snan_v[j] = wr[j] && snan;
         assign sub_v[j]  = wr[j] && sub;
         assign res_d[j*DP_W +: DP_W] = wr[j]   ? dp_val
                                      : keep[j] ? prev_i[j*DP_W +: DP_W]
                                      : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o <= '0;
         inv_o <= 1'b0;
         den_o <= 1'b0;
      end else begin
         res_o <= res_d;
         inv_o <= |snan_v;
         den_o <= |sub_v;
      end
   end

   // R6: nothing above 128 bits survives a short VEX-style/extended write
   p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_i != 2'd0 && vlen_i == 2'd0) |=> (res_o[DST_W-1:128] == '0));

   // R7: legacy writes leave the upper part as it was
   p_legacy_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_i == 2'd0) |=> (res_o[DST_W-1:128] == $past(prev_i[DST_W-1:128])));

   // R4: zero masking clears a masked lane
   p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_EN && enc_i[1] && mmode_i == 2'd2 && !mask_i[0]) |=> (res_o[DP_W-1:0] == '0));

   // R4: merge masking holds a masked lane
   p_merge_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_EN && enc_i[1] && mmode_i == 2'd1 && !mask_i[0])
      |=> (res_o[DP_W-1:0] == $past(prev_i[DP_W-1:0])));

   // R11: an all-clear mask under masking raises no flag
   p_no_flag_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_EN && enc_i[1] && (mmode_i == 2'd1 || mmode_i == 2'd2) && mask_i == '0)
      |=> (!inv_o && !den_o));

endmodule

// File: tb/tb_sp2dp_widen.sv
`timescale 1ns/1ps
module tb_sp2dp_widen;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] src = '0;
   logic [511:0] prev = '0;
   logic [7:0]   mask = '0;
   logic [1:0]   vlen = '0, mmode = '0, enc = '0;
   logic         bcast = 1'b0;
   logic [511:0] res;
   logic         inv, den;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   sp2dp_widen dut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .prev_i(prev), .mask_i(mask),
      .vlen_i(vlen), .mmode_i(mmode), .bcast_i(bcast), .enc_i(enc),
      .res_o(res), .inv_o(inv), .den_o(den)
   );

   function automatic logic [63:0] ref_cvt(input logic [31:0] x,
                                           output bit is_inv, output bit is_den);
      logic [7:0]  e = x[30:23];
      logic [22:0] f = x[22:0];
      is_inv = 0; is_den = 0;
      if (e == 8'hff) begin
         if (f == 0) return {x[31], 11'h7ff, 52'd0};
         is_inv = !f[22];
         return {x[31], 11'h7ff, 1'b1, f[21:0], 29'd0};
      end
      if (e == 0) begin
         int p;
         logic [22:0] fr;
         if (f == 0) return {x[31], 63'd0};
         is_den = 1;
         p = 22;
         while (!f[p]) p--;
         fr = 23'(f << (23 - p));
         return {x[31], 11'(p + 874), fr, 29'd0};
      end
      return {x[31], 11'(int'(e) + 896), f, 29'd0};
   endfunction

   function automatic logic [511:0] ref_model(output bit fi, output bit fd);
      int  lanes;
      bit  ext, mon, bc, li, ld;
      logic [511:0] r = '0;
      fi = 0; fd = 0;
      ext   = (enc >= 2);
      lanes = (enc == 0 || vlen == 0) ? 2 : (vlen == 1) ? 4 : 8;
      mon   = ext && (mmode == 1 || mmode == 2);
      bc    = ext && bcast;
      for (int j = 0; j < 8; j++) begin
         if (j >= lanes) r[64*j +: 64] = (enc == 0) ? prev[64*j +: 64] : 64'd0;
         else if (mon && !mask[j]) r[64*j +: 64] = (mmode == 1) ? prev[64*j +: 64] : 64'd0;
         else begin
            r[64*j +: 64] = ref_cvt(bc ? src[31:0] : src[32*j +: 32], li, ld);
            fi |= li; fd |= ld;
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [511:0] er, input bit ei, input bit ed);
      n_tests++;
      if (res !== er || inv !== ei || den !== ed) begin
         n_fail++;
         $display("FAIL %s: res=%h inv=%0b den=%0b expected res=%h inv=%0b den=%0b",
                  tag, res, inv, den, er, ei, ed);
      end
   endtask

   // drive at a falling edge, let one rising edge register, check at next falling edge
   task automatic apply(input string tag);
      logic [511:0] er;
      bit ei, ed;
      er = ref_model(ei, ed);
      @(posedge clk);
      @(negedge clk);
      check(tag, er, ei, ed);
   endtask

   function automatic logic [31:0] pick_sp(input int k);
      logic [31:0] r = $urandom;
      case (k % 8)
         0: r[30:23] = 8'h00;
         1: r[30:0]  = '0;
         2: begin r[30:23] = 8'hff; r[22:0] = '0; end
         3: begin r[30:23] = 8'hff; r[22] = 1'b0; r[0] = 1'b1; end
         4: begin r[30:23] = 8'hff; r[22] = 1'b1; end
         default: if (r[30:23] == 8'h00 || r[30:23] == 8'hff) r[30:23] = 8'h40;
      endcase
      return r;
   endfunction

   task automatic fill_src(input int cls);
      for (int j = 0; j < 8; j++) src[32*j +: 32] = pick_sp(cls < 0 ? int'($urandom) : cls);
   endtask

   task automatic fill_prev();
      for (int j = 0; j < 16; j++) prev[32*j +: 32] = $urandom;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12 reset", '0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      fill_prev();

      // R3 normal values, extended, full length
      enc = 2; vlen = 2; mmode = 0; fill_src(5);
      apply("R3 normal widen");
      src[31:0] = 32'h3f80_0000;   // 1.0
      apply("R3 one");
      check("R3 one value", res, inv, den);
      n_tests++;
      if (res[63:0] !== 64'h3ff0_0000_0000_0000) begin
         n_fail++; $display("FAIL R3: lane0=%h expected 3ff0000000000000", res[63:0]);
      end

      // R1 length codes
      for (int v = 0; v < 4; v++) begin
         vlen = 2'(v); enc = 1; fill_src(-1); fill_prev();
         apply("R1 length map");
      end
      // R6 short extended write clears upper bits
      enc = 2; vlen = 0; fill_prev(); apply("R6 upper zero");
      enc = 3; vlen = 1; apply("R6 upper zero 256");

      // R7 legacy: fixed length and upper bits kept, mask/bcast ignored
      enc = 0; vlen = 2; mmode = 2; mask = 8'h00; bcast = 1; fill_src(5); fill_prev();
      apply("R7 legacy ignores len/mask/bcast");
      enc = 1; vlen = 2; apply("R7 vex ignores mask/bcast");
      bcast = 0;

      // R4 masking
      enc = 2; vlen = 2; mask = 8'hA5;
      mmode = 1; fill_prev(); apply("R4 merge");
      mmode = 2; apply("R4 zero");
      mmode = 0; apply("R4 mode none writes all");
      mmode = 3; apply("R4 mode code3 writes all");

      // R5 broadcast
      mmode = 1; mask = 8'h3C; bcast = 1; fill_src(5); apply("R5 broadcast");
      bcast = 0;

      // R8 subnormal, R9 zero/inf, R10 nan
      mmode = 0; fill_src(0); apply("R8 subnormals");
      src = '0; src[31:0] = 32'h0000_0001; apply("R8 smallest subnormal");
      src[31:0] = 32'h007f_ffff; apply("R8 largest subnormal");
      fill_src(1); apply("R9 signed zeros");
      fill_src(2); apply("R9 infinities");
      fill_src(3); apply("R10 signalling nan");
      fill_src(4); apply("R10 quiet nan");

      // R11 flags from unwritten lanes suppressed
      src = '0; src[32*5 +: 32] = 32'h7f80_0001; src[32*6 +: 32] = 32'h0000_0010;
      vlen = 0; apply("R11 out-of-length lanes");
      vlen = 2; mmode = 2; mask = 8'h9F; apply("R11 masked lanes");
      mask = 8'h20; apply("R11 written lane flags");

      // R2 random mixed
      for (int i = 0; i < 400; i++) begin
         fill_src(-1); fill_prev();
         mask = $urandom; vlen = $urandom; mmode = $urandom;
         enc = $urandom; bcast = $urandom;
         apply("R2 random lane placement");
      end

      // R12 reset clears
      rst_n = 1'b0; #1;
      check("R12 async reset", '0, 0, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule